// File: doc/BRIEF.md
# Serial Register-Access Port

This block is a serial slave that gives a host access to two 12-bit registers: an input value register and a control register. The host lowers an active-low frame line, then clocks 16 bits in on a data line with a serial clock. The first four bits form a header: a direction flag and a three-bit register address. The other twelve bits are the payload. A write frame loads the payload into the addressed register. A read frame returns the addressed register on a serial output in the same frame, right after the header.

The serial clock, frame line and data input are brought into a faster system clock domain through synchronizer flops, and their edges are detected there. Both registers are available as parallel outputs for the logic that uses them. The serial output has an enable, so the pad logic can drive it or release it. A control-register bit picks the idle state of the released pin: floating, or pulled low. The pad electrical behaviour and the converter that uses the input value are not part of this block.

Top module: `serial_reg_port`

## Requirements
- R1: A frame is 16 bits, MSB first, captured on falling serial-clock edges. Bit 15 is the direction (0 write, 1 read), bits 14:12 are the address and bits 11:0 the payload. A write to address 3'b001 loads the input register. The register output changes no later than 4 system clocks after the 16th falling edge, even while the frame line is still low.
- R2: A write to address 3'b111 loads the control register in the same way.
- R3: Writes to address 3'b000 (no-operation) or to 3'b010 through 3'b110 (reserved) change neither register.
- R4: If the frame line rises before the 16th falling edge, the partial frame is dropped and no register changes.
- R5: After 16 bits, further serial-clock edges are ignored until the frame line goes high and falls again. Only then is a new frame accepted.
- R6: On a read, the output enable rises after the 5th rising serial-clock edge. Then the 12 register bits appear MSB first, one new bit after each rising edge from the 5th to the 16th.
- R7: The output enable drops after the 16th falling edge, or when the frame line rises, whichever comes first. It stays low throughout write frames.
- R8: Reads of address 3'b000 or of reserved addresses return twelve zero bits.
- R9: The pulldown-enable output equals bit 6 of the control register. The serial output is 0 whenever its enable is low.
- R10: A synchronous reset clears both registers, the output enable and the serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| frame_n_i | input | 1 | Active-low frame line, asynchronous |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data pin |
| sdo_pd_en_o | output | 1 | Idle pulldown select for the released pin |
| in_reg_o | output | 12 | Input register value |
| ctrl_reg_o | output | 12 | Control register value |

## Verification
A bit counter that has drifted shows at the register outputs as a shifted payload or a missing update. It also shows as an output enable that rises on the wrong rising edge. Both can be seen within one frame. A wrong capture or wrong header decode corrupts the parallel outputs a few system clocks after the 16th falling edge. A readout register that shifts at the wrong time puts the wrong bit on the serial output at the very next rising edge. That is why the bench samples every read bit and checks the enable before every rising edge.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_NOP   = 3'b000,
    ADDR_INPUT = 3'b001,
    ADDR_CTRL  = 3'b111
  } sreg_addr_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_INPUT = 2'd1,
    TGT_CTRL  = 2'd2
  } sreg_tgt_e;

  // Map a header address to the register it reaches (reserved -> none)
  function automatic sreg_tgt_e decode_tgt(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_INPUT: return TGT_INPUT;
      ADDR_CTRL:  return TGT_CTRL;
      default:    return TGT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sreg_sync_edge.sv
module sreg_sync_edge #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

endmodule

// File: rtl/sreg_frame_rx.sv
module sreg_frame_rx #(
  parameter int FRAME_W = 16,
  parameter int HDR_W   = 4,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_hi,
  input  logic               frame_fall,
  input  logic               sclk_fall,
  input  logic               sdi,
  output logic               frm_active,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic [HDR_W-1:0]   hdr,
  output logic               word_done,
  output logic [FRAME_W-1:0] word
);

  logic [FRAME_W-2:0] shreg;
  logic               shift_en;

  // A falling edge is taken only inside an open frame and before it is full
  assign shift_en  = frm_active && sclk_fall && (bit_cnt != CNT_W'(FRAME_W));
  assign word_done = shift_en && (bit_cnt == CNT_W'(FRAME_W - 1));
  assign word      = {shreg, sdi};
  assign hdr       = shreg[HDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_active <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
    end else if (frame_hi) begin
      frm_active <= 1'b0;
    end else if (frame_fall) begin
      frm_active <= 1'b1;
      bit_cnt    <= '0;
    end else if (shift_en) begin
      shreg   <= {shreg[FRAME_W-3:0], sdi};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // R5
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(FRAME_W));

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    frame_fall |=> (bit_cnt == '0) && frm_active);

endmodule

// File: rtl/sreg_readout.sv
module sreg_readout #(
  parameter int DATA_W  = 12,
  parameter int HDR_W   = 4,
  localparam int FRAME_W = DATA_W + HDR_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_active,
  input  logic              sclk_rise,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              hdr_rd,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              frame_end,
  output logic              sdo,
  output logic              oe
);

  logic [DATA_W-1:0] obuf;
  logic              load_ev;
  logic              shift_ev;

  // Header complete and the next rising edge arrives: present the MSB
  assign load_ev  = frm_active && sclk_rise && hdr_rd && (bit_cnt == CNT_W'(HDR_W));
  assign shift_ev = oe && sclk_rise && (bit_cnt > CNT_W'(HDR_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      oe   <= 1'b0;
      obuf <= '0;
    end else begin
      if (!frm_active || frame_end) oe <= 1'b0;
      else if (load_ev)             oe <= 1'b1;
      if (load_ev)       obuf <= rd_data;
      else if (shift_ev) obuf <= {obuf[DATA_W-2:0], 1'b0};
    end
  end

  assign sdo = oe & obuf[DATA_W-1];

  // R6
  oe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> (bit_cnt == CNT_W'(HDR_W)) && frm_active);

  // R7
  oe_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (oe && (!frm_active || frame_end)) |=> !oe);

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int DATA_W      = 12,
  parameter int PD_BIT      = 6,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = sreg_pkg::ADDR_W,
  localparam int HDR_W      = ADDR_W + 1,
  localparam int FRAME_W    = DATA_W + HDR_W,
  localparam int CNT_W      = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              frame_n_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              sdo_pd_en_o,
  output logic [DATA_W-1:0] in_reg_o,
  output logic [DATA_W-1:0] ctrl_reg_o
);
  import sreg_pkg::*;

  // Synchronized pins: [2] frame line, [1] serial clock, [0] data in
  logic [2:0] pin_lvl, pin_rise, pin_fall;
  logic [1:0] unused_edges;

  sreg_sync_edge #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk), .rst (rst),
    .d   ({frame_n_i, sclk_i, sdi_i}),
    .lvl (pin_lvl), .rise (pin_rise), .fall (pin_fall)
  );
  assign unused_edges = {pin_rise[2] | pin_rise[0], pin_fall[0]};

  logic               frm_active, word_done;
  logic [CNT_W-1:0]   bit_cnt;
  logic [HDR_W-1:0]   hdr;
  logic [FRAME_W-1:0] word;

  sreg_frame_rx #(.FRAME_W(FRAME_W), .HDR_W(HDR_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .frame_hi   (pin_lvl[2]),
    .frame_fall (pin_fall[2]),
    .sclk_fall  (pin_fall[1]),
    .sdi        (pin_lvl[0]),
    .frm_active (frm_active),
    .bit_cnt    (bit_cnt),
    .hdr        (hdr),
    .word_done  (word_done),
    .word       (word)
  );

  // Write decode from the completed word
  sreg_tgt_e   wr_tgt;
  logic        in_we, ctrl_we;
  assign wr_tgt  = decode_tgt(word[FRAME_W-2 -: ADDR_W]);
  assign in_we   = word_done && !word[FRAME_W-1] && (wr_tgt == TGT_INPUT);
  assign ctrl_we = word_done && !word[FRAME_W-1] && (wr_tgt == TGT_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_reg_o   <= '0;
      ctrl_reg_o <= '0;
    end else begin
      if (in_we)   in_reg_o   <= word[DATA_W-1:0];
      if (ctrl_we) ctrl_reg_o <= word[DATA_W-1:0];
    end
  end

  // Read select from the header captured so far
  sreg_tgt_e         rd_tgt;
  logic [DATA_W-1:0] rd_data;
  assign rd_tgt = decode_tgt(hdr[ADDR_W-1:0]);
  always_comb begin
    case (rd_tgt)
      TGT_INPUT: rd_data = in_reg_o;
      TGT_CTRL:  rd_data = ctrl_reg_o;
      default:   rd_data = '0;
    endcase
  end

  sreg_readout #(.DATA_W(DATA_W), .HDR_W(HDR_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .frm_active(frm_active),
    .sclk_rise (pin_rise[1]),
    .bit_cnt   (bit_cnt),
    .hdr_rd    (hdr[HDR_W-1]),
    .rd_data   (rd_data),
    .frame_end (word_done),
    .sdo       (sdo_o),
    .oe        (sdo_oe_o)
  );

  assign sdo_pd_en_o = ctrl_reg_o[PD_BIT];

  // R1
  in_update_chk: assert property (@(posedge clk) disable iff (rst)
    in_we |=> in_reg_o == $past(word[DATA_W-1:0]));

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we |=> $stable(ctrl_reg_o));

  // R3
  in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_we |=> $stable(in_reg_o));

endmodule

// File: tb/tb_serial_reg_port.sv
module tb_serial_reg_port;

  localparam int HP = 6;  // system clocks per serial half period

  logic        clk = 1'b0;
  logic        rst;
  logic        sclk, frame_n, sdi;
  logic        sdo, sdo_oe, pd_en;
  logic [11:0] in_reg, ctrl_reg;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [11:0] in_m, ctrl_m;

  always #10 clk = ~clk;  // 50 MHz

  serial_reg_port dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .frame_n_i(frame_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sdo_pd_en_o(pd_en),
    .in_reg_o(in_reg), .ctrl_reg_o(ctrl_reg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_read(input logic [2:0] a);
    if (a == 3'b001) return in_m;
    if (a == 3'b111) return ctrl_m;
    return 12'h000;
  endfunction

  function automatic logic [15:0] mk(input bit rd, input logic [2:0] a, input logic [11:0] d);
    return {rd, a, d};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Shift nbits of w (MSB first); record read bits and enable mistakes
  task automatic shift_bits(input logic [15:0] w, input int nbits,
                            output logic [11:0] rd, output int oe_bad);
    rd = '0; oe_bad = 0;
    frame_n = 1'b0;
    wait_clk(HP);
    for (int k = 1; k <= nbits; k++) begin
      sdi = w[16-k];
      sclk = 1'b1;
      wait_clk(HP);
      if (k >= 5) begin
        rd[16-k] = sdo;
        if (sdo_oe !== w[15]) oe_bad++;
        if (!sdo_oe && sdo !== 1'b0) oe_bad++;
      end else if (sdo_oe !== 1'b0) oe_bad++;
      sclk = 1'b0;
      wait_clk(HP);
    end
    if (nbits == 16 && sdo_oe !== 1'b0) oe_bad++;
  endtask

  task automatic end_frame();
    frame_n = 1'b1;
    wait_clk(HP);
  endtask

  task automatic apply_model(input logic [15:0] w);
    if (!w[15] && w[14:12] == 3'b001) in_m = w[11:0];
    if (!w[15] && w[14:12] == 3'b111) ctrl_m = w[11:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] rd;
    int          bad;
    logic [15:0] w;

    void'($urandom(32'h5EED1234));
    rst = 1'b1; sclk = 1'b0; frame_n = 1'b1; sdi = 1'b0;
    in_m = '0; ctrl_m = '0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);

    // R10: reset state
    chk("R10 in", in_reg, 0);
    chk("R10 ctrl", ctrl_reg, 0);
    chk("R10 oe/sdo", {sdo_oe, sdo, pd_en}, 0);

    // R1: write input register; visible before the frame line rises
    w = mk(0, 3'b001, 12'hA5C);
    shift_bits(w, 16, rd, bad);
    chk("R1 in update while frame low", in_reg, 12'hA5C);
    chk("R7 oe low in write", bad, 0);
    end_frame(); apply_model(w);

    // R2, R9: control write sets pulldown select
    w = mk(0, 3'b111, 12'h040);
    shift_bits(w, 16, rd, bad); end_frame(); apply_model(w);
    chk("R2 ctrl update", ctrl_reg, 12'h040);
    chk("R9 pulldown on", pd_en, 1);
    chk("R9 sdo idle zero", {sdo_oe, sdo}, 0);

    // R6, R7: read input register
    w = mk(1, 3'b001, 12'h000);
    shift_bits(w, 16, rd, bad);
    chk("R6 read input", rd, 12'hA5C);
    chk("R7 oe window", bad, 0);
    end_frame();

    // R3: no-op and reserved writes
    for (int a = 0; a < 7; a++) begin
      if (a == 1) continue;
      w = mk(0, 3'(a), 12'hFFF);
      shift_bits(w, 16, rd, bad); end_frame();
      chk("R3 in kept", in_reg, 12'hA5C);
      chk("R3 ctrl kept", ctrl_reg, 12'h040);
    end

    // R8: reads of no-op and reserved addresses
    w = mk(1, 3'b000, 12'h000);
    shift_bits(w, 16, rd, bad); end_frame();
    chk("R8 nop read", {rd, 20'(bad)}, 0);
    w = mk(1, 3'b101, 12'h000);
    shift_bits(w, 16, rd, bad); end_frame();
    chk("R8 reserved read", {rd, 20'(bad)}, 0);

    // R4: partial write frames are dropped
    w = mk(0, 3'b001, 12'h123);
    shift_bits(w, 10, rd, bad); end_frame();
    chk("R4 drop after 10", in_reg, 12'hA5C);
    shift_bits(w, 15, rd, bad); end_frame();
    chk("R4 drop after 15", in_reg, 12'hA5C);

    // R7: read aborted mid-data releases the pin
    w = mk(1, 3'b111, 12'h000);
    shift_bits(w, 8, rd, bad);
    chk("R7 oe driven mid read", sdo_oe, 1);
    end_frame();
    chk("R7 oe released on frame rise", {sdo_oe, sdo}, 0);

    // R5: extra edges with frame line held low are ignored
    w = mk(0, 3'b001, 12'h3C3);
    shift_bits(w, 16, rd, bad); apply_model(w);
    w = mk(0, 3'b001, 12'h777);
    shift_bits(w, 16, rd, bad);
    chk("R5 extra edges ignored", in_reg, 12'h3C3);
    end_frame();
    shift_bits(w, 16, rd, bad); end_frame(); apply_model(w);
    chk("R5 next frame after refall", in_reg, 12'h777);

    // Random frames against the model (R1, R2, R3, R6, R8, R9)
    for (int n = 0; n < 60; n++) begin
      logic [11:0] exp_rd;
      w = mk(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 12'($urandom));
      if (n % 5 == 0) w[14:12] = (n % 10 == 0) ? 3'b111 : 3'b001;
      exp_rd = exp_read(w[14:12]);
      shift_bits(w, 16, rd, bad); end_frame();
      if (w[15]) chk("R6 random read", rd, exp_rd);
      chk("R7 random oe", bad, 0);
      apply_model(w);
      chk("R1 random in", in_reg, in_m);
      chk("R2 random ctrl", ctrl_reg, ctrl_m);
      chk("R9 random pulldown", pd_en, ctrl_m[6]);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule